// File: doc/BRIEF.md
# Packed-24 Pixel Bus Unpacker

This block takes a 64-bit pixel bus on which 24-bit true-colour pixels arrive packed eight to every three bus words. It turns them back into a stream of one pixel per dot clock. The whole block runs in the dot clock domain. Bus loads are marked by a strobe that is high on three of every eight dot clocks, which models a load clock running at three eighths of the dot rate.

A line-activity input is sampled at each load. The first load that sees it high starts the line. With the delayed-start option set, the line starts two loads later instead. The load that starts the line is word 0 of a three-word group. From there a position counter runs 0, 1, 2 on every load, and it keeps running through blanking. Completed groups are held in a staging register. Each one is sent out as eight consecutive pixels. Output of a group begins at a load whose position matches a 2-bit alignment select, so the output runs one group behind the input. A line whose active part stops in the middle of a group raises a one-cycle error pulse, and the partial group is dropped.

Top module: `pk24_unpacker`

## Requirements
- R1: While reset is high, and on the cycle after it is released, `pix_vld` is 0, `pix` is 0 and `grp_err` is 0.
- R2: Group bit k holds bit k%64 of word k/64 of the group. Pixel j of the group is group bits [24j+23:24j], and pixels leave in order j = 0 to 7.
- R3: With `late_start` = 0, the first load that samples `line_active` high after a load that sampled it low (or after reset) is word 0.
- R4: With `late_start` = 1, the first two loads that sample `line_active` high carry no pixel data. The third such load is word 0.
- R5: Load positions count 0, 1, 2, 0, ... from word 0 onward. They keep counting on loads that sample `line_active` low, so the last group of a line is still sent out during blanking.
- R6: A completed group is sent out starting on the first later load whose position equals `edge_sel` (0 to 2). Its pixel 0 is present, with `pix_vld` high, in the cycle after that load edge, and `pix_vld` then stays high for eight cycles.
- R7: Whenever `pix_vld` is 0, `pix` is 0.
- R8: A load that samples `line_active` low while the line is running and the position is not 0 makes `grp_err` high for exactly the next cycle. The unfinished group is never sent out, and complete lines raise no error.
- R9: Under the three-in-eight load pattern, the groups of a line come out back to back, with no idle cycle between them.
- R10: A synchronous reset drops any buffered or staged group and any line that is running. After reset, nothing is sent out until a new line starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Bus load strobe, three of every eight cycles |
| line_active | input | 1 | High during the active part of a line, sampled at loads |
| late_start | input | 1 | 1 starts the line two loads after the first high sample |
| edge_sel | input | 2 | Load position (0 to 2) that sets when group output begins |
| bus_word | input | 64 | Packed bus word, captured on a load |
| pix | output | 24 | Unpacked pixel, zero when not valid |
| pix_vld | output | 1 | Pixel valid |
| grp_err | output | 1 | One-cycle pulse: line ended in the middle of a group |

## Verification
A group starts coming out one edge after the matching load of the next three-load window. The bench therefore logs the cycle of every load and predicts the first valid cycle as load index word0+3+edge_sel. It predicts the last valid cycle as load index word0+3·groups+edge_sel plus seven. The error pulse is due in the cycle after the load that samples the line low. All outputs are sampled on the falling edge after the rising edge that updates them. Pixel values are compared in order against a queue filled by a reference packer.

// File: rtl/pk24_pkg.sv
package pk24_pkg;

   // line synchroniser states
   typedef enum logic [1:0] {
      SY_WAIT = 2'd0,   // blanking, waiting for first high sample
      SY_HOLD = 2'd1,   // delayed start, skipping loads
      SY_RUN  = 2'd2    // active line, words are captured
   } sync_st_t;

endpackage

// File: rtl/pk24_load_tracker.sv
module pk24_load_tracker
   import pk24_pkg::*;
#(
   parameter int GRP_WORDS   = 3,
   parameter int START_DELAY = 2,
   parameter int POS_W       = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic             line_active,
   input  logic             late_start,
   input  logic [POS_W-1:0] edge_sel,
   output logic             cap_en,
   output logic [POS_W-1:0] cap_pos,
   output logic             align_hit,
   output logic             grp_err
);

   localparam bit HAS_DLY = (START_DELAY > 0);
   localparam int DLY_W   = (START_DELAY > 1) ? $clog2(START_DELAY) : 1;
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(GRP_WORDS - 1);

   sync_st_t         st, st_nx;
   logic [POS_W-1:0] phase;
   logic [POS_W-1:0] cur_pos;
   logic             synced;
   logic             err_q;
   logic             word0;
   logic             dly_done;
   logic             act_ld;
   logic             blank_ld;

   assign act_ld   = load_en &  line_active;
   assign blank_ld = load_en & ~line_active;

   generate
      if (HAS_DLY) begin : g_dly
         logic [DLY_W-1:0] dly_cnt;
         always_ff @(posedge clk) begin
            if (rst || st != SY_HOLD) begin
               dly_cnt <= '0;
            end else if (act_ld) begin
               dly_cnt <= dly_cnt + 1'b1;
            end
         end
         assign dly_done = (dly_cnt == DLY_W'(START_DELAY - 1));
      end else begin : g_nodly
         assign dly_done = 1'b1;
      end
   endgenerate

   always_comb begin
      st_nx = st;
      word0 = 1'b0;
      unique case (st)
         SY_WAIT: begin
            if (act_ld) begin
               if (late_start && HAS_DLY) begin
                  st_nx = SY_HOLD;
               end else begin
                  st_nx = SY_RUN;
                  word0 = 1'b1;
               end
            end
         end
         SY_HOLD: begin
            if (blank_ld) begin
               st_nx = SY_WAIT;
            end else if (act_ld && dly_done) begin
               st_nx = SY_RUN;
               word0 = 1'b1;
            end
         end
         SY_RUN: begin
            if (blank_ld) st_nx = SY_WAIT;
         end
         default: st_nx = SY_WAIT;
      endcase
   end

   assign cur_pos = word0 ? '0 : phase;

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= SY_WAIT;
         phase  <= '0;
         synced <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st    <= st_nx;
         err_q <= blank_ld && (st == SY_RUN) && (phase != '0);
         if (load_en) begin
            phase <= (cur_pos == LAST_POS) ? '0 : cur_pos + 1'b1;
         end
         if (word0) synced <= 1'b1;
      end
   end

   assign cap_en    = act_ld & (word0 | (st == SY_RUN));
   assign cap_pos   = cur_pos;
   assign align_hit = load_en & synced & (cur_pos == edge_sel);
   assign grp_err   = err_q;

   // R8
   err_once_chk: assert property (@(posedge clk) disable iff (rst)
      grp_err |=> !grp_err);

   // R3
   sync_src_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(synced) |-> $past(load_en && line_active));

   // R4
   hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
      (st == SY_HOLD && $past(st) != SY_HOLD) |-> $past(late_start && act_ld));

endmodule

// File: rtl/pk24_group_buf.sv
module pk24_group_buf #(
   parameter int BUS_W     = 64,
   parameter int GRP_WORDS = 3,
   parameter int POS_W     = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       cap_en,
   input  logic [POS_W-1:0]           cap_pos,
   input  logic [BUS_W-1:0]           bus_word,
   input  logic                       take,
   output logic [BUS_W*GRP_WORDS-1:0] grp_data,
   output logic                       grp_full
);

   localparam int GRP_BITS = BUS_W * GRP_WORDS;
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(GRP_WORDS - 1);

   logic [BUS_W-1:0]    held [GRP_WORDS-1];
   logic [GRP_BITS-1:0] asm_grp;
   logic [GRP_BITS-1:0] stage;
   logic                full_q;
   logic                last_word;

   assign last_word = cap_en && (cap_pos == LAST_POS);

   genvar gi;
   generate
      for (gi = 0; gi < GRP_WORDS - 1; gi++) begin : g_slot
         always_ff @(posedge clk) begin
            if (rst) begin
               held[gi] <= '0;
            end else if (cap_en && cap_pos == POS_W'(gi)) begin
               held[gi] <= bus_word;
            end
         end
         assign asm_grp[gi*BUS_W +: BUS_W] = held[gi];
      end
   endgenerate

   assign asm_grp[(GRP_WORDS-1)*BUS_W +: BUS_W] = bus_word;

   always_ff @(posedge clk) begin
      if (rst) begin
         stage  <= '0;
         full_q <= 1'b0;
      end else begin
         if (last_word) stage <= asm_grp;
         full_q <= last_word | (full_q & ~take);
      end
   end

   assign grp_data = stage;
   assign grp_full = full_q;

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (last_word && full_q) |-> take);

endmodule

// File: rtl/pk24_serializer.sv
module pk24_serializer #(
   parameter int PIX_W   = 24,
   parameter int GRP_PIX = 8
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic [PIX_W*GRP_PIX-1:0] grp_data,
   output logic [PIX_W-1:0]         pix,
   output logic                     pix_vld
);

   localparam int IDX_W = (GRP_PIX > 1) ? $clog2(GRP_PIX) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GRP_PIX - 1);

   logic [PIX_W*GRP_PIX-1:0] obuf;
   logic [PIX_W-1:0]         lanes [GRP_PIX];
   logic [IDX_W-1:0]         idx;
   logic                     busy;

   genvar gi;
   generate
      for (gi = 0; gi < GRP_PIX; gi++) begin : g_lane
         assign lanes[gi] = obuf[gi*PIX_W +: PIX_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         obuf <= '0;
         idx  <= '0;
         busy <= 1'b0;
      end else if (start) begin
         obuf <= grp_data;
         idx  <= '0;
         busy <= 1'b1;
      end else if (busy) begin
         if (idx == LAST_IDX) begin
            busy <= 1'b0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assign pix     = busy ? lanes[idx] : '0;
   assign pix_vld = busy;

   // R6
   burst_len_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && idx != LAST_IDX) |=> busy);

   // R2
   idx_step_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !start && idx != LAST_IDX) |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/pk24_unpacker.sv
module pk24_unpacker #(
   parameter int PIX_W       = 24,
   parameter int BUS_W       = 64,
   parameter int GRP_PIX     = 8,
   parameter int GRP_WORDS   = 3,
   parameter int START_DELAY = 2,
   localparam int POS_W      = (GRP_WORDS > 1) ? $clog2(GRP_WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic             line_active,
   input  logic             late_start,
   input  logic [POS_W-1:0] edge_sel,
   input  logic [BUS_W-1:0] bus_word,
   output logic [PIX_W-1:0] pix,
   output logic             pix_vld,
   output logic             grp_err
);

   localparam int GRP_BITS = BUS_W * GRP_WORDS;

   generate
      if (PIX_W * GRP_PIX != GRP_BITS) begin : g_bad_pack
         $error("pk24_unpacker: pixel group and word group widths differ");
      end
      if (GRP_WORDS < 2) begin : g_bad_words
         $error("pk24_unpacker: a group needs at least two bus words");
      end
   endgenerate

   logic             cap_en;
   logic [POS_W-1:0] cap_pos;
   logic             align_hit;
   logic             take;
   logic             grp_full;
   logic [GRP_BITS-1:0] grp_data;

   pk24_load_tracker #(
      .GRP_WORDS   (GRP_WORDS),
      .START_DELAY (START_DELAY),
      .POS_W       (POS_W)
   ) u_tracker (
      .clk         (clk),
      .rst         (rst),
      .load_en     (load_en),
      .line_active (line_active),
      .late_start  (late_start),
      .edge_sel    (edge_sel),
      .cap_en      (cap_en),
      .cap_pos     (cap_pos),
      .align_hit   (align_hit),
      .grp_err     (grp_err)
   );

   assign take = align_hit & grp_full;

   pk24_group_buf #(
      .BUS_W     (BUS_W),
      .GRP_WORDS (GRP_WORDS),
      .POS_W     (POS_W)
   ) u_gbuf (
      .clk      (clk),
      .rst      (rst),
      .cap_en   (cap_en),
      .cap_pos  (cap_pos),
      .bus_word (bus_word),
      .take     (take),
      .grp_data (grp_data),
      .grp_full (grp_full)
   );

   pk24_serializer #(
      .PIX_W   (PIX_W),
      .GRP_PIX (GRP_PIX)
   ) u_ser (
      .clk      (clk),
      .rst      (rst),
      .start    (take),
      .grp_data (grp_data),
      .pix      (pix),
      .pix_vld  (pix_vld)
   );

   // R6
   start_vld_chk: assert property (@(posedge clk) disable iff (rst)
      take |=> (pix_vld && pix == $past(grp_data[PIX_W-1:0])));

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (!pix_vld && !grp_err));

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!pix_vld && !$past(take)) |-> (pix == '0));

endmodule

// File: tb/pk24_unpacker_bench.sv
module pk24_unpacker_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        load_en = 1'b0;
   logic        line_active = 1'b0;
   logic        late_start = 1'b0;
   logic [1:0]  edge_sel = 2'd0;
   logic [63:0] bus_word = '0;
   logic [23:0] pix;
   logic        pix_vld;
   logic        grp_err;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int lpos = 0;
   int ld_hist[$];
   logic [23:0] exp_q[$];
   bit mon_on = 1'b0;
   int vld_cnt = 0;
   int vld_first = 0;
   int vld_last = 0;
   int err_cnt = 0;
   int err_cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pk24_unpacker u_pk24_unpacker (
      .clk         (clk),
      .rst         (rst),
      .load_en     (load_en),
      .line_active (line_active),
      .late_start  (late_start),
      .edge_sel    (edge_sel),
      .bus_word    (bus_word),
      .pix         (pix),
      .pix_vld     (pix_vld),
      .grp_err     (grp_err)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // reference packer: little-endian pixels across the 192-bit group
   function automatic logic [191:0] pack_grp(input logic [23:0] p [8]);
      logic [191:0] g;
      for (int k = 0; k < 8; k++) g[24*k +: 24] = p[k];
      return g;
   endfunction

   // output monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (mon_on && !rst) begin
         if (grp_err) begin
            err_cnt++;
            err_cyc = cyc;
         end
         if (pix_vld) begin
            if (vld_cnt == 0) vld_first = cyc;
            vld_last = cyc;
            vld_cnt++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected pixel", pix, 0);
            end else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               chk(pix == e, "R2 pixel value", pix, e);
            end
         end else begin
            chk(pix == '0, "R7 idle pixel", pix, 0);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      cyc++;
      @(negedge clk);
   endtask

   // one load, then idle cycles keeping a 3-in-8 pattern (gaps 3,3,2)
   task automatic bus_load(input bit act, input logic [63:0] w);
      load_en = 1'b1;
      line_active = act;
      bus_word = w;
      tick();
      ld_hist.push_back(cyc);
      load_en = 1'b0;
      bus_word = '0;
      repeat ((lpos == 2) ? 1 : 2) tick();
      lpos = (lpos + 1) % 3;
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   task automatic run_line(input bit late, input int sel, input int ngrp, input bit extra);
      int lead, nact, tail, w0;
      late_start = late;
      edge_sel = 2'(sel);
      ld_hist.delete();
      vld_cnt = 0;
      err_cnt = 0;
      lead = late ? 1 : 0;
      nact = 3*ngrp + (extra ? 1 : 0) + (late ? 2 : 0);
      tail = 6 + ((3 - ((lead + nact + 6) % 3)) % 3);
      for (int i = 0; i < lead; i++) bus_load(1'b0, rnd64());
      if (late) begin
         // R4: two active loads with junk data before word 0
         bus_load(1'b1, rnd64());
         bus_load(1'b1, rnd64());
      end
      w0 = ld_hist.size();
      for (int g = 0; g < ngrp; g++) begin
         logic [23:0]  p [8];
         logic [191:0] gb;
         for (int k = 0; k < 8; k++) begin
            p[k] = 24'($urandom());
            exp_q.push_back(p[k]);
         end
         gb = pack_grp(p);
         for (int k = 0; k < 3; k++) bus_load(1'b1, gb[64*k +: 64]);
      end
      if (extra) bus_load(1'b1, rnd64());
      for (int i = 0; i < tail; i++) bus_load(1'b0, '0);
      repeat (4) tick();
      chk(vld_cnt == 8*ngrp, "R6 pixel count", vld_cnt, 8*ngrp);
      if (ngrp > 0) begin
         chk(vld_first == ld_hist[w0 + 3 + sel], late ? "R4 first pixel cycle" : "R3 first pixel cycle",
             vld_first, ld_hist[w0 + 3 + sel]);
         chk(vld_last == ld_hist[w0 + 3*ngrp + sel] + 7, "R5 drain in blanking",
             vld_last, ld_hist[w0 + 3*ngrp + sel] + 7);
         chk(vld_last - vld_first + 1 == 8*ngrp, "R9 back to back",
             vld_last - vld_first + 1, 8*ngrp);
      end
      if (extra) begin
         chk(err_cnt == 1, "R8 error pulse count", err_cnt, 1);
         chk(err_cyc == ld_hist[w0 + 3*ngrp + 1], "R8 error cycle",
             err_cyc, ld_hist[w0 + 3*ngrp + 1]);
      end else begin
         chk(err_cnt == 0, "R8 no error on full line", err_cnt, 0);
      end
      chk(exp_q.size() == 0, "R2 all pixels emitted", exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) tick();
      rst = 1'b0;
      tick();
      // R1: state right after reset release
      chk(pix_vld == 1'b0, "R1 valid after reset", pix_vld, 0);
      chk(pix == '0, "R1 pixel after reset", pix, 0);
      chk(grp_err == 1'b0, "R1 error after reset", grp_err, 0);
      mon_on = 1'b1;

      // directed: every alignment select, immediate start (R3, R5, R6, R9)
      for (int s = 0; s < 3; s++) run_line(1'b0, s, 2, 1'b0);
      // directed: delayed start (R4)
      run_line(1'b1, 1, 2, 1'b0);
      run_line(1'b1, 2, 1, 1'b0);
      // directed: line ends mid-group (R8)
      run_line(1'b0, 0, 1, 1'b1);
      run_line(1'b1, 2, 2, 1'b1);

      // R10: reset with a full group staged
      late_start = 1'b0;
      edge_sel = 2'd1;
      vld_cnt = 0;
      for (int k = 0; k < 3; k++) bus_load(1'b1, rnd64());
      rst = 1'b1;
      load_en = 1'b0;
      line_active = 1'b0;
      repeat (2) tick();
      rst = 1'b0;
      for (int i = 0; i < 6; i++) bus_load(1'b0, '0);
      repeat (4) tick();
      chk(vld_cnt == 0, "R10 staged group dropped", vld_cnt, 0);
      run_line(1'b0, 1, 1, 1'b0);

      // constrained random lines
      for (int n = 0; n < 14; n++) begin
         run_line(1'($urandom_range(0, 1)), int'($urandom_range(0, 2)),
                  int'($urandom_range(1, 4)), (n % 5 == 4));
      end

      summary();
   end

endmodule